// File: doc/BRIEF.md
# Time-Ordered Multi-Channel Frame Merger

This block joins the frame streams of several input channels into a single output stream in which frames and subblocks come out in timestamp order. Each channel is read from the head of a word buffer. The block sees whether the buffer has a word, looks at that word, and pops it. Every word has a 2-bit type tag and a 32-bit payload. The tag values are 00 for data, 01 for a frame header, 10 for a subblock header and 11 for an end marker. A header carries its timestamp in the low `TS_W` bits of the payload and zeros above them. Each channel already delivers its frames and its subblocks in rising timestamp order, so the block only has to merge the streams and never sorts.

When every channel holds a frame header, the block opens an output frame with the smallest frame timestamp. Every channel whose header matches that value takes part; all other channels keep their frames for a later round. The block then polls the taking-part channels in turn, compares the subblock timestamps they present, and emits the earliest subblock. If several channels share that earliest timestamp, their hits go out under one shared subblock header. Once every taking-part channel has reached its end marker, the frame closes with a word of type 11 whose payload is a CRC32 over the frame.

Top module: `ts_frame_merger`

## Requirements
- R1: Until every channel presents a word at its head, no output word is offered and no channel is popped, except to discard bad words as described in R10.
- R2: An output frame opens with a type-01 word whose payload is the smallest frame timestamp among the heads. Only channels with that frame timestamp give words to the frame. The other channels keep their frames for later output frames.
- R3: Within an output frame, subblock headers (type 10) appear in ascending timestamp order. Each carries the timestamp zero-extended in its payload.
- R4: When several taking-part channels present the same smallest subblock timestamp, one type-10 header is emitted. It is followed by the data words of those channels, taken channel by channel in ascending channel index.
- R5: A subblock whose timestamp is held by one channel only goes out unchanged: its header, then its data words in order.
- R6: An output frame closes, with one type-11 word, once every taking-part channel has consumed its end marker. A channel with an empty frame (header directly followed by end marker) adds nothing but its timestamp match.
- R7: The payload of the closing word is a CRC32 with polynomial 0x04C11DB7, processed MSB first over 32-bit payloads. The initial value is 0xFFFFFFFF and the result is XORed with 0xFFFFFFFF. It covers the payloads of all earlier words of the frame, from the frame header through the last data word.
- R8: While `out_valid` is high and `out_ready` is low, `out_word` holds and `out_valid` stays high. No word is lost or repeated under back-pressure.
- R9: A channel is popped only while its `in_valid` is high, and only in a cycle where its word is sent or taken into the current output word.
- R10: A word whose type is not allowed in the current step is popped and dropped, and `err_flag` goes high and stays high until reset. Examples are a non-header word where a frame header is expected, and a frame header inside a subblock.
- R11: After reset, `out_valid`, `in_pop` and `err_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | NCH×34 | Head word of each channel buffer: type tag [33:32], payload [31:0] |
| in_valid | input | NCH | Channel buffer holds a head word |
| in_pop | output | NCH | Remove the head word of the channel |
| out_word | output | 34 | Output word: type tag [33:32], payload [31:0] |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word |
| err_flag | output | 1 | Sticky flag for an unexpected word type |

## Verification
The bench builds the merger with its defaults: four channels and 16-bit timestamps. Four channels give enough cases for full interleaving of distinct subblock timestamps, for three-way and four-way fusion of equal timestamps, and for a lone early frame that leaves three channels waiting with their frames held. With 16-bit timestamps, the expected stream can be built from readable small values. The bench also drops input gaps and output back-pressure on the polling loop, so that words must hold while the round-robin scan waits on a channel with no word.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
    localparam int PAY_W = 32;
    localparam int WORD_W = PAY_W + 2;
    localparam logic [1:0] K_DATA = 2'b00;
    localparam logic [1:0] K_FHDR = 2'b01;
    localparam logic [1:0] K_SHDR = 2'b10;
    localparam logic [1:0] K_END  = 2'b11;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [2:0] {
        S_WAIT,
        S_SCAN,
        S_SHDR,
        S_DRAIN,
        S_CLOSE
    } mstate_e;
endpackage

// File: rtl/tsm_crc_step.sv
module tsm_crc_step #(
    parameter int DW = 32
) (
    input  logic [31:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [31:0]   crc_out
);
    import tsm_pkg::*;

    always_comb begin
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = c[31] ^ data[i];
            c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/tsm_head_min.sv
module tsm_head_min #(
    parameter int NCH  = 4,
    parameter int TS_W = 16
) (
    input  logic [NCH-1:0][TS_W-1:0] ts,
    output logic [TS_W-1:0]          min_ts,
    output logic [NCH-1:0]           eq_mask
);
    always_comb begin
        min_ts = ts[0];
        for (int i = 1; i < NCH; i++) begin
            if (ts[i] < min_ts) min_ts = ts[i];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_eq
        assign eq_mask[g] = (ts[g] == min_ts);
    end
endmodule

// File: rtl/tsm_first_set.sv
module tsm_first_set #(
    parameter int NCH = 4,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]   mask,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ts_frame_merger.sv
module ts_frame_merger
    import tsm_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int TS_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0][33:0]     in_word,
    input  logic [NCH-1:0]           in_valid,
    output logic [NCH-1:0]           in_pop,
    output logic [33:0]              out_word,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     err_flag
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        mstate_e          st;
        logic [NCH-1:0]   part;
        logic [NCH-1:0]   done;
        logic [IDX_W-1:0] ptr;
        logic [TS_W-1:0]  best;
        logic             have;
        logic [NCH-1:0]   grp;
        logic [31:0]      crc;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic [NCH-1:0][TS_W-1:0] head_ts;
    logic [NCH-1:0]           bad_mask;
    logic [TS_W-1:0]          min_ts;
    logic [NCH-1:0]           eq_mask;
    logic [IDX_W-1:0]         cur;
    logic [31:0]              crc_nx;
    logic [1:0]               ptr_kind;
    logic [1:0]               cur_kind;
    logic                     hs;

    for (genvar g = 0; g < NCH; g++) begin : g_head
        assign head_ts[g]  = in_word[g][TS_W-1:0];
        assign bad_mask[g] = in_valid[g] && (in_word[g][33:32] != K_FHDR);
    end

    tsm_head_min #(.NCH(NCH), .TS_W(TS_W)) u_min (
        .ts(head_ts), .min_ts(min_ts), .eq_mask(eq_mask)
    );

    tsm_first_set #(.NCH(NCH)) u_first (
        .mask(r_q.grp), .idx(cur)
    );

    tsm_crc_step #(.DW(PAY_W)) u_crc (
        .crc_in(r_q.crc), .data(out_word[31:0]), .crc_out(crc_nx)
    );

    assign ptr_kind = in_word[r_q.ptr][33:32];
    assign cur_kind = in_word[cur][33:32];
    assign hs       = out_valid && out_ready;
    assign err_flag = r_q.err;

    // Output word selection
    always_comb begin
        out_valid = 1'b0;
        out_word  = '0;
        unique case (r_q.st)
            S_WAIT: begin
                out_valid = (&in_valid) && !(|bad_mask);
                out_word  = {K_FHDR, PAY_W'(min_ts)};
            end
            S_SHDR: begin
                out_valid = 1'b1;
                out_word  = {K_SHDR, PAY_W'(r_q.best)};
            end
            S_DRAIN: begin
                out_valid = in_valid[cur] && (cur_kind == K_DATA);
                out_word  = in_word[cur];
            end
            S_CLOSE: begin
                out_valid = 1'b1;
                out_word  = {K_END, ~r_q.crc};
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        logic             adv;
        logic [NCH-1:0]   ptr_bit;
        r_d     = r_q;
        in_pop  = '0;
        adv     = 1'b0;
        ptr_bit = '0;
        ptr_bit[r_q.ptr] = 1'b1;
        if (hs && out_word[33:32] != K_END) r_d.crc = crc_nx;
        unique case (r_q.st)
            S_WAIT: begin
                if (|bad_mask) begin
                    in_pop = bad_mask;
                    r_d.err = 1'b1;
                end else if (hs) begin
                    in_pop   = eq_mask;
                    r_d.part = eq_mask;
                    r_d.done = '0;
                    r_d.ptr  = '0;
                    r_d.have = 1'b0;
                    r_d.grp  = '0;
                    r_d.st   = S_SCAN;
                end
            end
            S_SCAN: begin
                if (!r_q.part[r_q.ptr] || r_q.done[r_q.ptr]) begin
                    adv = 1'b1;
                end else if (in_valid[r_q.ptr]) begin
                    if (ptr_kind == K_END) begin
                        in_pop[r_q.ptr]   = 1'b1;
                        r_d.done[r_q.ptr] = 1'b1;
                        adv = 1'b1;
                    end else if (ptr_kind == K_SHDR) begin
                        if (!r_q.have || head_ts[r_q.ptr] < r_q.best) begin
                            r_d.best = head_ts[r_q.ptr];
                            r_d.grp  = ptr_bit;
                            r_d.have = 1'b1;
                        end else if (head_ts[r_q.ptr] == r_q.best) begin
                            r_d.grp = r_q.grp | ptr_bit;
                        end
                        adv = 1'b1;
                    end else begin
                        in_pop[r_q.ptr] = 1'b1;
                        r_d.err = 1'b1;
                    end
                end
                if (adv) begin
                    if (r_q.ptr == IDX_W'(NCH - 1)) begin
                        r_d.ptr = '0;
                        r_d.st  = r_d.have ? S_SHDR : S_CLOSE;
                    end else begin
                        r_d.ptr = r_q.ptr + IDX_W'(1);
                    end
                end
            end
            S_SHDR: begin
                if (hs) begin
                    in_pop = r_q.grp;
                    r_d.st = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (in_valid[cur]) begin
                    if (cur_kind == K_DATA) begin
                        in_pop[cur] = hs;
                    end else if (cur_kind == K_FHDR) begin
                        in_pop[cur] = 1'b1;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.grp[cur] = 1'b0;
                        if (r_d.grp == '0) begin
                            r_d.st   = S_SCAN;
                            r_d.ptr  = '0;
                            r_d.have = 1'b0;
                        end
                    end
                end
            end
            S_CLOSE: begin
                if (hs) begin
                    r_d.st  = S_WAIT;
                    r_d.crc = '1;
                end
            end
            default: r_d.st = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= S_WAIT;
            r_q.crc <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // R9
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop & ~in_valid) == '0);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R4
    data_one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_word[33:32] == K_DATA |-> $countones(in_pop) <= 1);

    // R1
    wait_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == S_WAIT && !(&in_valid) |-> !out_valid);
endmodule

// File: tb/tb_ts_frame_merger.sv
module tb_ts_frame_merger;
    localparam int NCH = 4;
    localparam int TSW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0][33:0] in_word = '0;
    logic [NCH-1:0]       in_valid = '0;
    logic [NCH-1:0]       in_pop;
    logic [33:0]          out_word;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic                 err_flag;

    ts_frame_merger #(.NCH(NCH), .TS_W(TSW)) dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_pop(in_pop), .out_word(out_word), .out_valid(out_valid),
        .out_ready(out_ready), .err_flag(err_flag)
    );

    always #2.5 clk = ~clk;

    logic [33:0] fq [NCH][$];
    logic [33:0] mq [NCH][$];
    logic [33:0] expq [$];
    int n_cmp = 0;
    int n_bad = 0;
    int rpct = 100;
    int vpct = 100;
    bit finished = 1'b0;

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [31:0] d);
        logic [31:0] c;
        c = c_in;
        for (int i = 31; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ d[i];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic emit(input logic [33:0] w, inout logic [31:0] c);
        expq.push_back(w);
        c = crc_step(c, w[31:0]);
    endtask

    // Reference merge from the requirements, applied to the model copies
    task automatic run_model();
        forever begin
            logic [31:0] c;
            logic [NCH-1:0] part, done;
            int mn;
            bit ok;
            ok = 1'b1;
            for (int i = 0; i < NCH; i++) begin
                while (mq[i].size() > 0 && mq[i][0][33:32] != 2'b01) void'(mq[i].pop_front());
                if (mq[i].size() == 0) ok = 1'b0;
            end
            if (!ok) break;
            mn = 1 << TSW;
            for (int i = 0; i < NCH; i++)
                if (int'(mq[i][0][TSW-1:0]) < mn) mn = int'(mq[i][0][TSW-1:0]);
            c = 32'hFFFF_FFFF;
            emit({2'b01, 32'(mn)}, c);
            part = '0;
            for (int i = 0; i < NCH; i++)
                if (int'(mq[i][0][TSW-1:0]) == mn) begin
                    part[i] = 1'b1;
                    void'(mq[i].pop_front());
                end
            done = '0;
            forever begin
                logic [NCH-1:0] grp;
                int sm;
                bit have;
                for (int i = 0; i < NCH; i++)
                    if (part[i] && !done[i] && mq[i][0][33:32] == 2'b11) begin
                        void'(mq[i].pop_front());
                        done[i] = 1'b1;
                    end
                have = 1'b0; grp = '0; sm = 0;
                for (int i = 0; i < NCH; i++)
                    if (part[i] && !done[i]) begin
                        int t;
                        t = int'(mq[i][0][TSW-1:0]);
                        if (!have || t < sm) begin sm = t; grp = '0; grp[i] = 1'b1; have = 1'b1; end
                        else if (t == sm) grp[i] = 1'b1;
                    end
                if (!have) break;
                emit({2'b10, 32'(sm)}, c);
                for (int i = 0; i < NCH; i++)
                    if (grp[i]) begin
                        void'(mq[i].pop_front());
                        while (mq[i].size() > 0 && mq[i][0][33:32] == 2'b00) emit(mq[i].pop_front(), c);
                    end
            end
            expq.push_back({2'b11, ~c});
        end
    endtask

    task automatic push_word(input int ch, input logic [33:0] w);
        fq[ch].push_back(w);
        mq[ch].push_back(w);
    endtask

    task automatic add_frame(input int ch, input int fts, input int nsub, input int base,
                             input int step, input int nd, input int tag);
        push_word(ch, {2'b01, 32'(fts)});
        for (int k = 0; k < nsub; k++) begin
            push_word(ch, {2'b10, 32'(base + k * step)});
            for (int j = 0; j < nd; j++) push_word(ch, {2'b00, 32'(tag * 4096 + k * 16 + j)});
        end
        push_word(ch, {2'b11, 32'h0});
    endtask

    task automatic wait_drain(input string req);
        int n;
        n = 0;
        while (expq.size() > 0 && n < 20000) begin @(posedge clk); n++; end
        repeat (20) @(posedge clk);
        check(expq.size() == 0, req, 34'(expq.size()), 34'd0);
    endtask

    // Channel buffers, output ready and scoreboard monitor
    always begin
        logic [NCH-1:0] cap_pop;
        logic cap_hs;
        logic [33:0] got;
        @(negedge clk);
        cap_pop = in_pop;
        cap_hs = out_valid && out_ready && rst_n;
        got = out_word;
        if (cap_hs) begin
            if (expq.size() == 0) check(1'b0, "R1 unexpected word", got, 34'h0);
            else begin
                logic [33:0] e;
                string tg;
                e = expq.pop_front();
                case (e[33:32])
                    2'b01: tg = "R2 frame header";
                    2'b10: tg = "R3 subblock header";
                    2'b00: tg = "R5 data word";
                    default: tg = "R7 closing CRC";
                endcase
                check(got == e, tg, got, e);
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NCH; i++) begin
            bit keep;
            if (cap_pop[i] && fq[i].size() > 0) void'(fq[i].pop_front());
            keep = in_valid[i] && !cap_pop[i];
            in_valid[i] = (fq[i].size() > 0) && (keep || int'($urandom % 100) < vpct);
            in_word[i] = (fq[i].size() > 0) ? fq[i][0] : 34'h0;
        end
        out_ready = int'($urandom % 100) < rpct;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(!out_valid && in_pop == '0 && !err_flag, "R11 reset",
              {out_valid, err_flag, 28'(in_pop)}, 34'h0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R3 R5 R6 R7: distinct subblock timestamps interleave
        for (int c = 0; c < NCH; c++) add_frame(c, 100, 3, 1 + c, 4, 2, c + 1);
        run_model();
        wait_drain("R3 interleave");

        // R4: equal subblock timestamps fuse
        for (int c = 0; c < NCH; c++) add_frame(c, 200, 2, (c == 3) ? 15 : 10, 5, c + 1, c + 5);
        run_model();
        wait_drain("R4 fuse");

        // R2: one lower frame timestamp leaves the others queued
        add_frame(0, 310, 2, 3, 3, 1, 9);
        add_frame(1, 310, 2, 4, 3, 1, 10);
        add_frame(2, 300, 2, 5, 2, 2, 11);
        add_frame(2, 310, 1, 3, 1, 1, 12);
        add_frame(3, 310, 2, 6, 1, 1, 13);
        run_model();
        wait_drain("R2 minimum frame");

        // R6: empty frame on one channel
        for (int c = 0; c < NCH; c++) add_frame(c, 400, (c == 1) ? 0 : 2, 2 + c, 2, 1, 14 + c);
        run_model();
        wait_drain("R6 empty frame");

        // R1: nothing moves while a channel lacks a frame header
        for (int c = 0; c < NCH - 1; c++) add_frame(c, 500, 1, 7, 1, 1, 20 + c);
        begin
            bit quiet;
            quiet = 1'b1;
            repeat (30) begin
                @(negedge clk);
                if (out_valid || in_pop != '0) quiet = 1'b0;
            end
            check(quiet, "R1 wait for all channels", 34'(quiet), 34'd1);
        end
        add_frame(NCH - 1, 500, 1, 7, 1, 2, 24);
        run_model();
        wait_drain("R1 release");

        // R8: back-pressure and input gaps
        rpct = 35; vpct = 50;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < NCH; c++)
                add_frame(c, 600 + r * 5 + ((c == r) ? 1 : 0), 3, 1 + (c % 2), 2 + c, 1 + (c % 3), 30 + r * 4 + c);
        for (int c = 0; c < NCH; c++) add_frame(c, 700, 1, 1, 1, 1, 50 + c);
        run_model();
        wait_drain("R8 back-pressure");
        rpct = 100; vpct = 100;
        @(negedge clk);
        check(!err_flag, "R10 no error on clean input", 34'(err_flag), 34'd0);

        // R10: a stray data word where a frame header belongs
        push_word(1, {2'b00, 32'hDEAD});
        for (int c = 0; c < NCH; c++) add_frame(c, 800, 2, 4 - c, 2, 1, 60 + c);
        run_model();
        wait_drain("R10 discard");
        @(negedge clk);
        check(err_flag, "R10 sticky error", 34'(err_flag), 34'd1);
        repeat (10) @(negedge clk);
        check(err_flag, "R10 error stays", 34'(err_flag), 34'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule